// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

Two independent timer/counter channels share one byte-wide register port. Each channel holds a low count byte and a high count byte and steps either once per machine cycle or once per recognised falling edge on its own count pin. A gate option lets an external level pin decide when counting is allowed. Four layouts are selected per channel: a 13-bit counter, a full 16-bit counter, an 8-bit counter that reloads from the high byte, and a fourth code that halts Channel 1 and splits Channel 0 into two separate byte counters.

An internal divider turns the system clock into a machine-cycle strobe, one pulse every `CYC_DIV` clocks. Count pins are sampled on that strobe, and a fall is recognised only when one sample reads high and the next reads low. Overflow from the all-ones state raises a sticky flag in the control register, and both flags are also driven out for an interrupt controller.

Register map (3-bit address): 0 = control, 1 = mode, 2 = Channel 0 low byte, 3 = Channel 0 high byte, 4 = Channel 1 low byte, 5 = Channel 1 high byte. Addresses 6 and 7 read as zero. Reads are combinational.

Top module: `dual_timer`

## Requirements
- R1: In timer operation, a running channel steps once per machine cycle. A machine cycle is `CYC_DIV` (default 12) clocks long, and its strobe falls on the `CYC_DIV`-th rising edge after reset is released and every `CYC_DIV` edges after that.
- R2: In counter operation, the count pin is sampled once per machine cycle. A step happens on the machine cycle whose sample is low when the previous sample was high. A pin that toggles every machine cycle is counted on every fall. A low pulse that spans no sampling edge is not counted.
- R3: With a channel's gate bit set, that channel counts only while its gate pin is high and its run bit is set. With the gate bit clear, the gate pin is ignored.
- R4: Mode code 00 counts `{high, low[4:0]}` as a 13-bit value. Every step leaves low-byte bits 7:5 at zero. A step from 0x1FFF wraps to zero and raises the overflow flag.
- R5: Mode code 01 counts `{high, low}` as a 16-bit value. A step from 0xFFFF wraps to zero and raises the overflow flag.
- R6: Mode code 10 steps only the low byte. A step from 0xFF loads the high byte into the low byte and raises the overflow flag. The high byte is unchanged.
- R7: Mode code 11 on Channel 0 splits it into two byte counters. The low byte uses Channel 0's run bit, gate and timer/counter choice, and sets flag 0 when it overflows. The high byte counts machine cycles while run bit 1 is set, and sets flag 1 when it overflows. While Channel 0 is split, Channel 1 counts whatever its run bit 1 is, and it cannot set flag 1.
- R8: Mode code 11 on Channel 1 halts Channel 1, so its count bytes change only through register writes.
- R9: Control register layout: bit 7 = flag 1, bit 6 = run 1, bit 5 = flag 0, bit 4 = run 0, bits 3:0 read as zero. Mode register layout: bit 7 = gate 1, bit 6 = counter select 1 (1 = count pin edges), bits 5:4 = mode 1; bits 3:0 hold the same fields for Channel 0.
- R10: A channel's overflow sets its flag, and the flag stays set until software writes it to 0. An overflow in the same cycle as a software write of 0 leaves the flag at 1.
- R11: A channel that is not running keeps its count. A write to a count byte takes effect at the next edge and replaces any step of that byte in the same cycle. In modes 00 and 01, a write to either byte of a channel cancels that channel's step for the cycle.
- R12: After reset, every register reads zero and both flag outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register address |
| regWr | input | 1 | Write strobe for the addressed register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the addressed register (combinational) |
| cntPin | input | 2 | Count pins, bit n for Channel n |
| gatePin | input | 2 | Gate level pins, bit n for Channel n |
| ovfFlags | output | 2 | Overflow flags, bit n for Channel n |

## Verification
The assertions assume that the count pins and gate pins are already synchronous to `clk`, and that the register port gives a stable address with every write strobe. The bench meets these assumptions by changing every input on the falling clock edge only. It follows the machine-cycle phase with its own modulo-`CYC_DIV` counter, which starts at reset release. It then lines up run-bit writes with strobe edges, so that an exact number of steps can be predicted and compared with an arithmetic model of each mode. Count-pin pulses are either held for whole machine cycles or deliberately placed between two sampling edges.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W  = 8;
  localparam int LOW13_W = 5;
  localparam int NUM_TMR = 2;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_LO0  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_HI0  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_LO1  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_HI1  = 3'd5;

  typedef enum logic [1:0] {
    MODE_13     = 2'b00,
    MODE_16     = 2'b01,
    MODE_RELOAD = 2'b10,
    MODE_SPLIT  = 2'b11
  } tmrMode_e;

  typedef struct packed {
    logic [NUM_TMR-1:0] stepMain;
    logic [NUM_TMR-1:0] stepHi;
    logic [NUM_TMR-1:0] wrLo;
    logic [NUM_TMR-1:0] wrHi;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_tick.sv
module tmr_tick #(
  parameter int CYC_DIV = 12,
  parameter int NUM_IN  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] pinIn,
  output logic              mcTick,
  output logic [NUM_IN-1:0] fallSeen
);
  localparam int CNT_W = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;

  logic [CNT_W-1:0] divCnt;

  assign mcTick = (divCnt == CNT_W'(CYC_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (mcTick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_edge
    logic sampNew, sampOld;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sampNew <= 1'b0;
        sampOld <= 1'b0;
      end else if (mcTick) begin
        sampNew <= pinIn[i];
        sampOld <= sampNew;
      end
    end
    assign fallSeen[i] = mcTick && sampOld && !sampNew;
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWr,
  input  logic [BYTE_W-1:0]     regWrData,
  input  logic                  mcTick,
  input  logic [NUM_TMR-1:0]    fallSeen,
  input  logic [NUM_TMR-1:0]    gatePin,
  input  logic [NUM_TMR-1:0]    ovfMain,
  input  logic [NUM_TMR-1:0]    ovfHi,
  output tmrStrobe_t            strobe,
  output logic [BYTE_W-1:0]     modeReg,
  output logic [BYTE_W-1:0]     ctrlView,
  output logic [NUM_TMR-1:0]    flagOut
);
  logic [NUM_TMR-1:0] runBit;
  logic [NUM_TMR-1:0] flagBit;
  logic [NUM_TMR-1:0] setFlag;
  logic [NUM_TMR-1:0] qual;
  logic [NUM_TMR-1:0] srcPulse;
  logic               splitOn;
  tmrMode_e           modeSel [NUM_TMR];

  always_comb begin
    for (int t = 0; t < NUM_TMR; t++) begin
      modeSel[t]  = tmrMode_e'(modeReg[4*t +: 2]);
      qual[t]     = !modeReg[4*t+3] || gatePin[t];
      srcPulse[t] = modeReg[4*t+2] ? fallSeen[t] : mcTick;
    end
  end

  assign splitOn = (modeSel[0] == MODE_SPLIT);

  always_comb begin
    strobe = '0;
    strobe.stepMain[0] = runBit[0] && qual[0] && srcPulse[0];
    strobe.stepMain[1] = (modeSel[1] != MODE_SPLIT) && (splitOn || runBit[1])
                         && qual[1] && srcPulse[1];
    strobe.stepHi[0]   = splitOn && runBit[1] && mcTick;
    for (int t = 0; t < NUM_TMR; t++) begin
      strobe.wrLo[t] = regWr && (regAddr == ADR_LO0 + ADDR_W'(2*t));
      strobe.wrHi[t] = regWr && (regAddr == ADR_HI0 + ADDR_W'(2*t));
    end
  end

  assign setFlag[0] = ovfMain[0];
  assign setFlag[1] = splitOn ? ovfHi[0] : (ovfMain[1] || ovfHi[1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      runBit  <= '0;
      flagBit <= '0;
    end else begin
      if (regWr && regAddr == ADR_MODE) modeReg <= regWrData;
      if (regWr && regAddr == ADR_CTRL) begin
        runBit  <= {regWrData[6], regWrData[4]};
        flagBit <= {regWrData[7], regWrData[5]} | setFlag;
      end else begin
        flagBit <= flagBit | setFlag;
      end
    end
  end

  assign ctrlView = {flagBit[1], runBit[1], flagBit[0], runBit[0], 4'b0000};
  assign flagOut  = flagBit;
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tmrMode_e          mode,
  input  logic              stepMain,
  input  logic              stepHi,
  input  logic              wrLo,
  input  logic              wrHi,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] loByte,
  output logic [BYTE_W-1:0] hiByte,
  output logic              ovfMain,
  output logic              ovfHi
);
  localparam int W13 = BYTE_W + LOW13_W;
  localparam int W16 = 2 * BYTE_W;

  logic [BYTE_W-1:0] loNext, hiNext;
  logic [W13:0]      sum13;
  logic [W16:0]      sum16;
  logic [BYTE_W:0]   sumLo, sumHi;
  logic              anyWr;

  assign anyWr = wrLo || wrHi;
  assign sum13 = {1'b0, hiByte, loByte[LOW13_W-1:0]} + (W13+1)'(1);
  assign sum16 = {1'b0, hiByte, loByte} + (W16+1)'(1);
  assign sumLo = {1'b0, loByte} + (BYTE_W+1)'(1);
  assign sumHi = {1'b0, hiByte} + (BYTE_W+1)'(1);

  always_comb begin
    loNext  = loByte;
    hiNext  = hiByte;
    ovfMain = 1'b0;
    ovfHi   = 1'b0;
    case (mode)
      MODE_13: if (stepMain && !anyWr) begin
        loNext  = BYTE_W'(sum13[LOW13_W-1:0]);
        hiNext  = sum13[LOW13_W +: BYTE_W];
        ovfMain = sum13[W13];
      end
      MODE_16: if (stepMain && !anyWr) begin
        loNext  = sum16[BYTE_W-1:0];
        hiNext  = sum16[BYTE_W +: BYTE_W];
        ovfMain = sum16[W16];
      end
      MODE_RELOAD: if (stepMain && !wrLo) begin
        loNext  = sumLo[BYTE_W] ? hiByte : sumLo[BYTE_W-1:0];
        ovfMain = sumLo[BYTE_W];
      end
      MODE_SPLIT: begin
        if (stepMain && !wrLo) begin
          loNext  = sumLo[BYTE_W-1:0];
          ovfMain = sumLo[BYTE_W];
        end
        if (stepHi && !wrHi) begin
          hiNext = sumHi[BYTE_W-1:0];
          ovfHi  = sumHi[BYTE_W];
        end
      end
    endcase
    if (wrLo) loNext = wrData;
    if (wrHi) hiNext = wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loByte <= '0;
      hiByte <= '0;
    end else begin
      loByte <= loNext;
      hiByte <= hiNext;
    end
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import tmr_pkg::*;
#(
  parameter int CYC_DIV = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regAddr,
  input  logic        regWr,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic [1:0]  cntPin,
  input  logic [1:0]  gatePin,
  output logic [1:0]  ovfFlags
);
  logic               mcTick;
  logic [NUM_TMR-1:0] fallSeen;
  tmrStrobe_t         strobe;
  logic [BYTE_W-1:0]  modeReg, ctrlView;
  logic [BYTE_W-1:0]  loB [NUM_TMR];
  logic [BYTE_W-1:0]  hiB [NUM_TMR];
  logic [NUM_TMR-1:0] ovfMainB, ovfHiB;

  tmr_tick #(.CYC_DIV(CYC_DIV), .NUM_IN(NUM_TMR)) u_tick (
    .clk(clk), .rstN(rstN), .pinIn(cntPin),
    .mcTick(mcTick), .fallSeen(fallSeen)
  );

  tmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .mcTick(mcTick), .fallSeen(fallSeen),
    .gatePin(gatePin), .ovfMain(ovfMainB), .ovfHi(ovfHiB),
    .strobe(strobe), .modeReg(modeReg), .ctrlView(ctrlView),
    .flagOut(ovfFlags)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_chan
    tmr_count u_cnt (
      .clk(clk), .rstN(rstN),
      .mode(tmrMode_e'(modeReg[4*t +: 2])),
      .stepMain(strobe.stepMain[t]), .stepHi(strobe.stepHi[t]),
      .wrLo(strobe.wrLo[t]), .wrHi(strobe.wrHi[t]),
      .wrData(regWrData),
      .loByte(loB[t]), .hiByte(hiB[t]),
      .ovfMain(ovfMainB[t]), .ovfHi(ovfHiB[t])
    );
  end

  always_comb begin
    case (regAddr)
      ADR_CTRL: regRdData = ctrlView;
      ADR_MODE: regRdData = modeReg;
      ADR_LO0:  regRdData = loB[0];
      ADR_HI0:  regRdData = hiB[0];
      ADR_LO1:  regRdData = loB[1];
      ADR_HI1:  regRdData = hiB[1];
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CYC_DIV = 12
) (
  input logic       clk,
  input logic       rstN,
  input logic       mcTick,
  input logic [7:0] modeReg,
  input logic [7:0] ctrlView,
  input logic [7:0] lo0,
  input logic [7:0] hi0,
  input logic [7:0] lo1,
  input logic [7:0] hi1,
  input logic [1:0] ovfMainB,
  input logic       step0,
  input logic       regWr,
  input logic [2:0] regAddr,
  input logic [7:0] regWrData
);
  int  gap;
  logic wr0, wr1;

  assign wr0 = regWr && (regAddr == 3'd2 || regAddr == 3'd3);
  assign wr1 = regWr && (regAddr == 3'd4 || regAddr == 3'd5);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gap <= 0;
    else if (mcTick) gap <= 0;
    else gap <= gap + 1;
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    mcTick |-> gap == CYC_DIV - 1);

  // R10
  flag0_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfMainB[0] |=> ctrlView[5]);

  // R10
  flag1_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfMainB[1] && modeReg[1:0] != 2'b11) |=> ctrlView[7]);

  // R11
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlView[4] && modeReg[1:0] != 2'b11 && !wr0) |=> ($stable(lo0) && $stable(hi0)));

  // R11
  wr_override_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 3'd2) |=> lo0 == $past(regWrData));

  // R8
  halt1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[5:4] == 2'b11 && !wr1) |=> ($stable(lo1) && $stable(hi1)));

  // R4
  low13_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[1:0] == 2'b00 && step0 && !wr0) |=> lo0[7:5] == 3'b000);
endmodule

bind dual_timer tmr_checker #(.CYC_DIV(CYC_DIV)) chk (
  .clk(clk), .rstN(rstN), .mcTick(mcTick), .modeReg(modeReg),
  .ctrlView(ctrlView), .lo0(loB[0]), .hi0(hiB[0]), .lo1(loB[1]),
  .hi1(hiB[1]), .ovfMainB(ovfMainB), .step0(strobe.stepMain[0]),
  .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData)
);

// File: tb/dual_timer_test.sv
module dual_timer_test;
  localparam int DIV = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regWr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [1:0] cntPin = '0;
  logic [1:0] gatePin = '0;
  logic [1:0] ovfFlags;

  int tests = 0;
  int fails = 0;
  int ph = 0;
  int cycles = 0;

  dual_timer #(.CYC_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .cntPin(cntPin),
    .gatePin(gatePin), .ovfFlags(ovfFlags)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rstN) ph <= 0;
    else ph <= (ph == DIV - 1) ? 0 : ph + 1;
  end

  initial begin
    wait (cycles > 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  // advance to the next falling edge after which a strobe edge follows
  task automatic toTickNeg();
    @(negedge clk);
    while (ph != DIV - 1) @(negedge clk);
  endtask

  task automatic pulses(input int n, input int half);
    for (int k = 0; k < n; k++) begin
      cntPin[0] = 1'b1;
      repeat (half) @(negedge clk);
      cntPin[0] = 1'b0;
      repeat (half) @(negedge clk);
    end
  endtask

  function automatic logic [16:0] model(input int m, input logic [7:0] h,
                                        input logic [7:0] l, input int n);
    logic f;
    logic [13:0] s;
    logic [16:0] w;
    f = 1'b0;
    for (int i = 0; i < n; i++) begin
      case (m)
        0: begin
          s = {1'b0, h, l[4:0]} + 14'd1;
          f = f | s[13]; h = s[12:5]; l = {3'b000, s[4:0]};
        end
        1: begin
          w = {1'b0, h, l} + 17'd1;
          f = f | w[16]; h = w[15:8]; l = w[7:0];
        end
        default: begin
          if (l == 8'hFF) begin l = h; f = 1'b1; end
          else l = l + 8'd1;
        end
      endcase
    end
    return {f, h, l};
  endfunction

  initial begin
    logic [7:0] v, a1;
    logic [7:0] hs, ls;
    logic [16:0] e;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R12 reset value", v, 8'h00);
    end
    check("R12 flag outputs", {6'b0, ovfFlags}, 8'h00);

    // R9 layout
    wr(3'd1, 8'hA5); rd(3'd1, v); check("R9 mode readback", v, 8'hA5);
    wr(3'd0, 8'h0F); rd(3'd0, v); check("R9 ctrl low bits zero", v, 8'h00);

    // R1 R4 R5 R6 sweep over channel, mode, preload
    for (int t = 0; t < 2; t++) begin
      for (int m = 0; m < 3; m++) begin
        for (int p = 0; p < 3; p++) begin
          case (p)
            0: begin hs = 8'hFF; ls = 8'hFE; end
            1: begin hs = 8'h12; ls = 8'hFF; end
            default: begin hs = 8'h00; ls = 8'h00; end
          endcase
          if (t == 0) wr(3'd1, {6'b000100, 2'(m)});
          else        wr(3'd1, {2'b00, 2'(m), 4'b0001});
          wr(3'd0, 8'h00);
          wr(3'(2 + 2*t), ls);
          wr(3'(3 + 2*t), hs);
          toTickNeg();
          wr(3'd0, (t == 0) ? 8'h10 : 8'h40);
          repeat (4) toTickNeg();
          e = model(m, hs, ls, 3);
          rd(3'(2 + 2*t), v); check("R1/R4/R5/R6 low byte", v, e[7:0]);
          rd(3'(3 + 2*t), v); check("R1/R4/R5/R6 high byte", v, e[15:8]);
          rd(3'd0, v);
          check("R10 sweep flag", {7'b0, (t == 0) ? v[5] : v[7]}, {7'b0, e[16]});
          wr(3'd0, 8'h00);
        end
      end
    end

    // R11 write overrides a step
    wr(3'd1, 8'h11); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    toTickNeg(); wr(3'd0, 8'h10);
    toTickNeg(); wr(3'd2, 8'h55);
    rd(3'd2, v); check("R11 write wins over step", v, 8'h55);
    rd(3'd3, v); check("R11 high byte untouched", v, 8'h00);
    wr(3'd0, 8'h00);

    // R10 hardware set beats software clear
    wr(3'd1, 8'h12); wr(3'd2, 8'hFF); wr(3'd3, 8'h10);
    toTickNeg(); wr(3'd0, 8'h10);
    toTickNeg(); wr(3'd0, 8'h10);
    rd(3'd0, v); check("R10 set priority", v, 8'h30);
    check("R10 flag output", {6'b0, ovfFlags}, 8'h01);
    rd(3'd2, v); check("R6 reload value", v, 8'h10);
    wr(3'd0, 8'h10);
    rd(3'd0, v); check("R10 software clear", v, 8'h10);
    wr(3'd0, 8'h00);
    repeat (40) @(negedge clk);
    rd(3'd2, v); check("R11 stopped holds", v, 8'h10);

    // R3 gate
    wr(3'd1, 8'h91); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    gatePin[1] = 1'b0;
    toTickNeg(); wr(3'd0, 8'h40);
    repeat (4) toTickNeg();
    rd(3'd4, v); check("R3 gate low blocks", v, 8'h00);
    gatePin[1] = 1'b1;
    repeat (3) toTickNeg();
    rd(3'd4, v); check("R3 gate high counts", v, 8'h03);
    wr(3'd0, 8'h00); gatePin[1] = 1'b0;

    // R8 Channel 1 halted
    wr(3'd1, 8'h31); wr(3'd4, 8'h44); wr(3'd0, 8'h40);
    repeat (40) @(negedge clk);
    rd(3'd4, v); check("R8 halted count", v, 8'h44);
    rd(3'd0, v); check("R8 no flag", v, 8'h40);
    wr(3'd0, 8'h00);

    // R7 split
    wr(3'd1, 8'h13); wr(3'd2, 8'h20); wr(3'd3, 8'hFE);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    toTickNeg(); wr(3'd0, 8'h40);
    repeat (2) toTickNeg();
    rd(3'd3, v); check("R7 high byte step", v, 8'hFF);
    rd(3'd4, a1);
    toTickNeg();
    rd(3'd3, v); check("R7 high byte wrap", v, 8'h00);
    rd(3'd0, v); check("R7 flag 1 from high byte", v, 8'hC0);
    rd(3'd2, v); check("R7 low byte idle", v, 8'h20);
    rd(3'd4, v); check("R7 channel 1 runs", v, a1 + 8'd1);
    @(negedge clk);
    wr(3'd0, 8'h00);
    repeat (3) toTickNeg();
    rd(3'd3, v); check("R7 high byte stops without run 1", v, 8'h01);
    rd(3'd4, v); check("R7 channel 1 ignores run 1", v, a1 + 8'd4);

    // R2 counter operation
    wr(3'd1, 8'h15); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    cntPin[0] = 1'b0;
    wr(3'd0, 8'h10);
    pulses(5, 2*DIV);
    repeat (4*DIV) @(negedge clk);
    rd(3'd2, v); check("R2 slow falls", v, 8'd5);
    pulses(6, DIV);
    repeat (4*DIV) @(negedge clk);
    rd(3'd2, v); check("R2 max rate falls", v, 8'd11);
    cntPin[0] = 1'b1;
    repeat (3*DIV) @(negedge clk);
    toTickNeg(); @(negedge clk);
    cntPin[0] = 1'b0;
    repeat (4) @(negedge clk);
    cntPin[0] = 1'b1;
    repeat (4*DIV) @(negedge clk);
    rd(3'd2, v); check("R2 short low missed", v, 8'd11);
    wr(3'd0, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule